// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a clocked sequencer that sits between a simple valid/ready host port and an external, unclocked static RAM of 1M words by 4 bits with active-low chip select, output enable and write enable. The host offers one request at a time: a 20-bit word address, a direction bit and, for writes, a 4-bit data nibble. The controller registers the address and then walks the memory strobes through a fixed sequence. Each phase lasts a whole number of clock cycles, derived from the clock period and the memory's nanosecond limits.

A read lowers chip select and output enable together and holds them for the access time. It samples the data bus on the last edge of that phase and hands the nibble back with a one-cycle valid pulse. A write lowers chip select and starts driving the data bus one cycle before write enable falls. It keeps the pulse low for the programmed width and releases the bus one cycle after write enable rises. Output enable stays high for the whole write. After every read, a turnaround phase lets the memory release the bus before the controller may drive it again.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever the host port shows ready, chip select, output enable and write enable are all high (1), the data direction output is 0 (bus released), and the response valid output is 0.
- R2: A read holds chip select and output enable low with write enable high for RD_CYC cycles (1 at the default 10 ns clock). It then presents the word stored at the address on the read data output together with a valid pulse exactly one cycle long.
- R3: A write drives the data bus (direction output 1) starting one cycle before write enable falls. It holds write enable and chip select low together for WP_CYC cycles (2 at the default clock) and keeps driving for one cycle after write enable rises. The memory stores the driven nibble at the address.
- R4: The memory address does not change while chip select stays low, so it is frozen throughout any interval in which chip select and write enable are both low.
- R5: Output enable is high in every cycle in which write enable is low.
- R6: The controller never enables its data drivers in the same cycle as the memory drives the bus. Between output enable rising at the end of a read and the direction output rising, at least TURN_CYC + 1 cycles pass.
- R7: Ready is low from the cycle after a request is accepted until that transfer completes, and each accepted request produces exactly one chip-select cycle on the memory.
- R8: Reset (active low, synchronous) taken in the middle of a transfer returns all strobes high and releases the data bus at the next edge, and no response valid pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host offers a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Word address of the request |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse marking valid read data |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 20 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq | inout | 4 | Bidirectional data bus |
| mem_dq_dir | output | 1 | 1 while the controller drives mem_dq |

## Verification
The hardest case to reach from the ports is a write accepted as early as possible after a read. Here the memory is still releasing the bus while the controller wants to start driving it. The stimulus forces this by issuing a write right after each read, to the same address and to others, and then reading the word back. Meanwhile a behavioural memory model flags any overlap of the two drivers, any address change under a low write strobe and any write pulse of the wrong length. A reset dropped into the write setup cycle shows that the bus is released without a stray response.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state type and cycle-count helpers for the SRAM controller.
// Assumes integer nanosecond timing values and a clock period of at least 1 ns.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctrl_state_t;

    // Whole clock cycles needed to cover a duration in nanoseconds.
    function automatic int cycles_for(input int dur_ns, input int period_ns);
        return (dur_ns + period_ns - 1) / period_ns;
    endfunction

    // Clamp a cycle count so that a phase is never empty.
    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Module: down counter that times one strobe phase.
// A load sets the count; done is high during the last cycle of the phase.
// Assumes a load value of at least 1.
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Final cycle of the phase.
    assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/sram_bus_io.sv
// Module: tri-state buffer for the bidirectional memory data bus.
// Drives the write data while dir is 1 and floats the bus otherwise; the bus
// value is always passed back for read capture.
module sram_bus_io #(
    parameter int DATA_W = 4
) (
    input  logic              dir,
    input  logic [DATA_W-1:0] wdata,
    inout  wire  [DATA_W-1:0] dq,
    output logic [DATA_W-1:0] din
);

    // Output driver, released to high impedance when not writing.
    assign dq  = dir ? wdata : {DATA_W{1'bz}};
    // Input path used when sampling read data.
    assign din = dq;

endmodule

// File: rtl/sram_ctrl_fsm.sv
// Module: strobe sequencer for an asynchronous SRAM.
// Accepts one request while idle, then steps through read access plus bus
// turnaround, or write setup, pulse and hold. All memory-side outputs are
// registered so that they change only on clock edges.
// Assumes the phase timer asserts done in the last cycle of each loaded phase.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 4,
    parameter int RD_CYC   = 1,
    parameter int WP_CYC   = 2,
    parameter int TURN_CYC = 1,
    parameter int CNT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              dir,
    output logic [DATA_W-1:0] wdata_out,
    input  logic [DATA_W-1:0] din,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_done
);

    ctrl_state_t state;
    logic        accept;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;

    // Pick which phase length to load into the timer.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(RD_CYC);
        if (accept && !req_write) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RD_CYC);
        end else if (state == ST_WR_SETUP) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WP_CYC);
        end else if (state == ST_RD_ACC && tmr_done) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TURN_CYC);
        end
    end

    // State register and registered memory strobes, address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cs_n      <= 1'b1;
            oe_n      <= 1'b1;
            we_n      <= 1'b1;
            dir       <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            mem_addr  <= '0;
            wdata_out <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        mem_addr <= req_addr;
                        cs_n     <= 1'b0;
                        if (req_write) begin
                            wdata_out <= req_wdata;
                            dir       <= 1'b1;
                            state     <= ST_WR_SETUP;
                        end else begin
                            oe_n  <= 1'b0;
                            state <= ST_RD_ACC;
                        end
                    end
                end
                ST_RD_ACC: begin
                    if (tmr_done) begin
                        rsp_rdata <= din;
                        rsp_valid <= 1'b1;
                        cs_n      <= 1'b1;
                        oe_n      <= 1'b1;
                        state     <= ST_TURN;
                    end
                end
                ST_TURN: begin
                    if (tmr_done) begin
                        state <= ST_IDLE;
                    end
                end
                ST_WR_SETUP: begin
                    we_n  <= 1'b0;
                    state <= ST_WR_PULSE;
                end
                ST_WR_PULSE: begin
                    if (tmr_done) begin
                        we_n  <= 1'b1;
                        state <= ST_WR_HOLD;
                    end
                end
                ST_WR_HOLD: begin
                    dir   <= 1'b0;
                    cs_n  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R1: an idle port means every strobe is parked high and the bus is free.
    assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && oe_n && we_n && !dir && !rsp_valid));

    // R2: the read data valid flag lasts a single cycle.
    assert_rvalid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R3: a low write strobe is always covered by chip select and our drivers.
    assert_we_covered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cs_n && dir));

    // R4: the address cannot move while the chip stays selected.
    assert_addr_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(mem_addr));

    // R5: the memory outputs stay disabled whenever write enable is low.
    assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    // R6: drivers turn on only after output enable has been high two cycles.
    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir) |-> ($past(oe_n) && $past(oe_n, 2)));

endmodule

// File: rtl/sram_async_ctrl.sv
// Module: top of the asynchronous SRAM controller.
// Converts nanosecond limits into cycle counts and joins the sequencer, the
// phase timer and the bus buffer. Assumes CLK_PERIOD_NS >= 1.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 4,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ACC_NS      = 10,
    parameter int T_WP_NS       = 7,
    parameter int T_BUS_OFF_NS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_dq_dir
);

    // Phase lengths in cycles; the write pulse gets one cycle of margin.
    localparam int RD_CYC   = at_least_one(cycles_for(T_ACC_NS, CLK_PERIOD_NS));
    localparam int WP_CYC   = cycles_for(T_WP_NS, CLK_PERIOD_NS) + 1;
    localparam int TURN_CYC = at_least_one(cycles_for(T_BUS_OFF_NS, CLK_PERIOD_NS));
    localparam int MAX_CYC  = max3(RD_CYC, WP_CYC, TURN_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic [DATA_W-1:0] wdata_out;
    logic [DATA_W-1:0] din;

    sram_ctrl_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .TURN_CYC (TURN_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .cs_n      (mem_cs_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .dir       (mem_dq_dir),
        .wdata_out (wdata_out),
        .din       (din),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_done  (tmr_done)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_bus_io #(
        .DATA_W (DATA_W)
    ) u_bus (
        .dir   (mem_dq_dir),
        .wdata (wdata_out),
        .dq    (mem_dq),
        .din   (din)
    );

endmodule

// File: tb/sram_async_ctrl_tb.sv
// Bench: scoreboard test of the SRAM controller against a behavioural memory.
module sram_async_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int EXP_WP     = 2;
    localparam int EXP_RD     = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [3:0]  rsp_rdata;
    logic [19:0] mem_addr;
    logic        mem_cs_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    wire  [3:0]  mem_dq;
    logic        mem_dq_dir;

    int tests = 0;
    int fails = 0;
    int accepted = 0;
    int cs_falls = 0;
    int wr_count = 0;

    logic [3:0] model_mem [int];
    logic [3:0] ref_mem [int];
    logic [3:0] exp_q [$];
    logic [19:0] pool [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq     (mem_dq),
        .mem_dq_dir (mem_dq_dir)
    );

    // Behavioural memory: drives when selected for read, plus one cycle of release delay.
    logic       model_hold = 1'b0;
    logic [3:0] model_rd;
    wire        model_on    = !mem_cs_n && !mem_oe_n && mem_we_n;
    wire        model_drive = model_on || model_hold;
    assign mem_dq = model_drive ? model_rd : 4'bzzzz;

    always @(posedge clk) model_hold <= model_on;

    always @(mem_addr, wr_count) begin
        model_rd = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 4'h0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory-side rule checker, sampled mid-cycle.
    logic        prev_low = 1'b0;
    logic        prev_rd = 1'b0;
    logic        prev_dir = 1'b0;
    logic        prev_cs_n = 1'b1;
    logic [19:0] prev_addr = '0;
    logic [3:0]  prev_dq = '0;
    int          low_cnt = 0;
    int          rd_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && !mem_we_n && prev_low)
                check(mem_addr == prev_addr, "R4 addr frozen", mem_addr, prev_addr);
            if (!mem_we_n)
                check(mem_oe_n, "R5 oe high during write", mem_oe_n, 1);
            if (!mem_cs_n && !mem_we_n && !prev_low)
                check(prev_dir, "R3 data driven before we falls", prev_dir, 1);
            if (!mem_cs_n && !mem_we_n) low_cnt++;
            if (!(!mem_cs_n && !mem_we_n) && prev_low) begin
                check(low_cnt == EXP_WP, "R3 write pulse length", low_cnt, EXP_WP);
                check(mem_dq_dir, "R3 data held after we rises", mem_dq_dir, 1);
                model_mem[int'(prev_addr)] = prev_dq;
                wr_count++;
                low_cnt = 0;
            end
            if (model_drive)
                check(!mem_dq_dir, "R6 bus contention", mem_dq_dir, 0);
            if (!mem_cs_n && !mem_oe_n) rd_cnt++;
            if (!(!mem_cs_n && !mem_oe_n) && prev_rd) begin
                check(rd_cnt == EXP_RD, "R2 read strobe length", rd_cnt, EXP_RD);
                rd_cnt = 0;
            end
            if (!mem_cs_n && prev_cs_n) cs_falls++;
        end
        prev_low  = !mem_cs_n && !mem_we_n;
        prev_rd   = !mem_cs_n && !mem_oe_n;
        prev_dir  = mem_dq_dir;
        prev_cs_n = mem_cs_n;
        prev_addr = mem_addr;
        prev_dq   = mem_dq;
    end

    // Scoreboard monitor: compares each returned word with the queued expectation.
    logic [3:0] exp_v;
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected read valid", 1, 0);
            end else begin
                exp_v = exp_q.pop_front();
                check(rsp_rdata == exp_v, "R2 read data", rsp_rdata, exp_v);
            end
        end
    end

    task automatic issue(input bit wr, input logic [19:0] a, input logic [3:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        accepted++;
        check(!req_ready, "R7 ready low while busy", req_ready, 0);
    endtask

    task automatic do_write(input logic [19:0] a, input logic [3:0] d);
        ref_mem[int'(a)] = d;
        issue(1'b1, a, d);
    endtask

    task automatic do_read(input logic [19:0] a);
        exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0);
        issue(1'b0, a, 4'h0);
    endtask

    task automatic drain();
        for (int i = 0; i < 8; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Watchdog: a hung run is a failure that still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) pool[i] = 20'($urandom);
        pool[0] = 20'h00000;
        pool[1] = 20'hFFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes idle after reset",
              {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        check(!mem_dq_dir, "R1 bus released after reset", mem_dq_dir, 0);
        check(req_ready, "R1 ready after reset", req_ready, 1);
        check(!rsp_valid, "R1 no valid after reset", rsp_valid, 0);

        // Directed: unwritten read, write, read back, end addresses.
        do_read(20'h00000);
        do_write(20'h00000, 4'hA);
        do_read(20'h00000);
        do_write(20'hFFFFF, 4'h5);
        do_read(20'hFFFFF);
        do_read(20'h00000);
        drain();

        // Read immediately followed by a write: turnaround corner (R6).
        for (int i = 0; i < 20; i++) begin
            do_read(pool[i % 16]);
            do_write(pool[i % 16], 4'($urandom));
            do_read(pool[i % 16]);
        end
        drain();

        // Random mixed traffic over a small address pool.
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 2) do_write(pool[$urandom % 16], 4'($urandom));
            else              do_read(pool[$urandom % 16]);
        end
        drain();
        check(req_ready, "R7 ready after traffic", req_ready, 1);
        check(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
        check(cs_falls == accepted, "R7 one memory cycle per request", cs_falls, accepted);

        // Reset in the write setup cycle (R8).
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 20'h12345;
        req_wdata = 4'h7;
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_dq_dir && !mem_cs_n, "R8 write setup reached", mem_dq_dir, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n, "R8 strobes high after abort",
              {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        check(!mem_dq_dir, "R8 bus released after abort", mem_dq_dir, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!rsp_valid, "R8 no valid after abort", rsp_valid, 0);
        end
        do_read(20'h12345);
        drain();
        check(exp_q.size() == 0, "R8 read after abort answered", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule